// File: doc/BRIEF.md
# 8-bit ALU with Per-Operation Status Flags

This block is the arithmetic and logic stage of a small 8-bit register machine. Each cycle that `en` is high, it takes two 8-bit operands and an operation code. One clock edge later it presents the 8-bit result, a strobe that says whether that result is to be written back, and the updated status flags. A status register inside the block holds the flags from one operation to the next. The with-carry operations take their carry from that register, so a chain of operations over several bytes needs no help from outside.

Each operation has a fixed set of flags it may change, and every other flag keeps its value. The compare operations change the flags in the same way as a subtraction, but they raise no write strobe and leave the result output as it was. Immediate forms of the operations use the same codes as the register forms, with the constant driven on `b`. Instruction decode, the register file and branching belong to the surrounding core.

Top module: `alu8_flags`

## Requirements
- R1: While reset is asserted and after it is released, `res` is 0x00, `res_we` is 0 and every flag is 0.
- R2: An operation issued with `en` high is reflected on `res`, `res_we` and `flags` exactly one clock edge later. A cycle with `en` low leaves `res` and `flags` unchanged and drives `res_we` to 0. Opcodes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 AND, 5 OR, 6 XOR, 7 set-bits, 8 clear-bits, 9 one's complement, 10 negate, 11 increment, 12 decrement, 13 set-all, 14 clear, 15 compare, 16 compare-with-carry. Flag bits: [0] C, [1] Z, [2] N, [3] V, [4] S, [5] H.
- R3: Add and add-with-carry (the latter adding the stored C) write a + b (+C). C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, Z means a zero result and N is bit 7 of the result.
- R4: Subtract and subtract-with-carry write a - b (- stored C). C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow. Z and N are set as in R3.
- R5: Subtract-with-carry and compare-with-carry also subtract the stored C. Their Z is 1 only when the result is zero and Z was already 1.
- R6: Compare and compare-with-carry set C, Z, N, V and H as the matching subtraction would, hold `res_we` at 0 and leave `res` unchanged.
- R7: AND, OR, XOR, set-bits (a OR b) and clear-bits (a AND NOT b) write their result, set Z and N from it, clear V, and leave C and H unchanged.
- R8: One's complement writes NOT a, sets C to 1, clears V, sets Z and N from the result, and leaves H unchanged.
- R9: Negate writes 0x00 - a and sets C, Z, N, V and H as the subtraction of a from zero would.
- R10: Increment and decrement write a + 1 and a - 1. V is set exactly when the result is 0x80 for increment or 0x7F for decrement. Z and N follow the result, and C and H are unchanged.
- R11: Set-all writes 0xFF and changes no flag. Clear writes 0x00, sets Z, clears N and V, and leaves C and H unchanged.
- R12: After every operation, S equals N XOR V.
- R13: Opcodes 17 to 31 raise no write strobe and change neither `res` nor any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Execute the operation presented this cycle |
| op | input | 5 | Operation code (see R2) |
| a | input | 8 | First operand, the destination value |
| b | input | 8 | Second operand or immediate constant |
| res | output | 8 | Registered result |
| res_we | output | 1 | Result is to be written back |
| flags | output | 6 | Status register {H,S,V,N,Z,C} |

## Verification
Every output is due on the first clock edge after the operation is issued, because the result, the write strobe and the status register all sit one register stage from the inputs. The driver presents inputs on the falling edge and queues its own prediction. The monitor pops that prediction on the next falling edge, which comes after the capturing rising edge and before any further change. The reference model tracks its own copy of the flags, so the carry chains and the sticky Z of the with-carry forms are checked across successive operations, and the idle cycles and illegal opcodes go through the same queue.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [4:0] op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  output logic [7:0] res,
  output logic       res_we,
  output logic [5:0] flags
);

  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADC  = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_SBC  = 5'd3;
  localparam logic [4:0] OP_AND  = 5'd4;
  localparam logic [4:0] OP_OR   = 5'd5;
  localparam logic [4:0] OP_XOR  = 5'd6;
  localparam logic [4:0] OP_SETB = 5'd7;
  localparam logic [4:0] OP_CLRB = 5'd8;
  localparam logic [4:0] OP_COM  = 5'd9;
  localparam logic [4:0] OP_NEG  = 5'd10;
  localparam logic [4:0] OP_INC  = 5'd11;
  localparam logic [4:0] OP_DEC  = 5'd12;
  localparam logic [4:0] OP_SER  = 5'd13;
  localparam logic [4:0] OP_CLR  = 5'd14;
  localparam logic [4:0] OP_CP   = 5'd15;
  localparam logic [4:0] OP_CPC  = 5'd16;

  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  logic       is_sub, use_c, ci;
  logic [7:0] xa, yb, ar;
  logic [8:0] sum9;
  logic [4:0] nib5;
  logic       ac, ah, av;
  logic [7:0] nr;
  logic       nwe;
  logic [5:0] nf;

  assign is_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) ||
                  (op == OP_CPC) || (op == OP_NEG) || (op == OP_DEC);
  assign use_c  = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);
  assign ci     = use_c & flags[FC];

  assign xa = (op == OP_NEG) ? 8'h00 : a;
  assign yb = (op == OP_NEG) ? a :
              ((op == OP_INC) || (op == OP_DEC)) ? 8'h01 : b;

  assign sum9 = is_sub ? ({1'b0, xa} - {1'b0, yb} - {8'b0, ci})
                       : ({1'b0, xa} + {1'b0, yb} + {8'b0, ci});
  assign nib5 = is_sub ? ({1'b0, xa[3:0]} - {1'b0, yb[3:0]} - {4'b0, ci})
                       : ({1'b0, xa[3:0]} + {1'b0, yb[3:0]} + {4'b0, ci});

  assign ar = sum9[7:0];
  assign ac = sum9[8];
  assign ah = nib5[4];
  assign av = is_sub ? ((xa[7] != yb[7]) && (ar[7] != xa[7]))
                     : ((xa[7] == yb[7]) && (ar[7] != xa[7]));

  always_comb begin
    nr  = res;
    nwe = 1'b0;
    nf  = flags;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        nr = ar; nwe = 1'b1;
        nf[FC] = ac; nf[FH] = ah; nf[FV] = av; nf[FN] = ar[7];
        nf[FZ] = (op == OP_SBC) ? ((ar == 8'h00) & flags[FZ]) : (ar == 8'h00);
      end
      OP_CP, OP_CPC: begin
        nf[FC] = ac; nf[FH] = ah; nf[FV] = av; nf[FN] = ar[7];
        nf[FZ] = (op == OP_CPC) ? ((ar == 8'h00) & flags[FZ]) : (ar == 8'h00);
      end
      OP_INC, OP_DEC: begin
        nr = ar; nwe = 1'b1;
        nf[FV] = av; nf[FN] = ar[7]; nf[FZ] = (ar == 8'h00);
      end
      OP_AND, OP_OR, OP_XOR, OP_SETB, OP_CLRB, OP_CLR: begin
        case (op)
          OP_AND:          nr = a & b;
          OP_OR, OP_SETB:  nr = a | b;
          OP_XOR:          nr = a ^ b;
          OP_CLRB:         nr = a & (8'hFF - b);
          default:         nr = a ^ a;
        endcase
        nwe = 1'b1;
        nf[FV] = 1'b0; nf[FN] = nr[7]; nf[FZ] = (nr == 8'h00);
      end
      OP_COM: begin
        nr = 8'hFF - a; nwe = 1'b1;
        nf[FC] = 1'b1; nf[FV] = 1'b0; nf[FN] = nr[7]; nf[FZ] = (nr == 8'h00);
      end
      OP_SER: begin
        nr = 8'hFF; nwe = 1'b1;
      end
      default: ;
    endcase
    nf[FS] = nf[FN] ^ nf[FV];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res    <= 8'h00;
      res_we <= 1'b0;
      flags  <= 6'h00;
    end else if (en) begin
      flags  <= nf;
      res_we <= nwe;
      if (nwe) res <= nr;
    end else begin
      res_we <= 1'b0;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !res_we && $stable(flags) && $stable(res));

  // R6
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && ((op == OP_CP) || (op == OP_CPC)) |=> !res_we && $stable(res));

  // R8
  com_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_COM) |=> flags[FC] && !flags[FV]);

  // R10
  incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && ((op == OP_INC) || (op == OP_DEC)) |=> $stable(flags[FC]) && $stable(flags[FH]));

  // R11
  ser_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_SER) |=> (res == 8'hFF) && $stable(flags));

  // R7
  logic_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op >= OP_AND) && (op <= OP_CLRB) |=> !flags[FV] && $stable(flags[FC]));

  // R13
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op > OP_CPC) |=> !res_we && $stable(flags) && $stable(res));

endmodule

// File: tb/alu8_flags_tb.sv
`timescale 1ns/1ps
module alu8_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] a = 8'h00, b = 8'h00;
  logic [7:0] res;
  logic res_we;
  logic [5:0] flags;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  alu8_flags u_dut (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b),
                    .res(res), .res_we(res_we), .flags(flags));

  logic [14:0] q_exp[$];
  string       q_tag[$];
  logic        drv = 1'b0, due = 1'b0;
  logic [7:0]  m_res = 8'h00;
  logic [5:0]  m_fl  = 6'h00;

  always @(posedge clk) due <= drv;

  logic [14:0] e;
  string t;
  always @(negedge clk) begin
    if (due && q_exp.size() > 0) begin
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_tests++;
      if ({res, res_we, flags} !== e) begin
        n_fail++;
        $display("FAIL %s: got res=%h we=%b flags=%b, expected res=%h we=%b flags=%b",
                 t, res, res_we, flags, e[14:7], e[6], e[5:0]);
      end
    end
  end

  task automatic issue(input logic ien, input logic [4:0] o, input logic [7:0] x,
                       input logic [7:0] y, input string tag);
    int u, sv, c, hn;
    logic [7:0] r;
    logic we;
    logic [5:0] f;
    @(negedge clk);
    en = ien; op = o; a = x; b = y;
    r = m_res; we = 1'b0; f = m_fl;
    if (ien) begin
      c = m_fl[0];
      case (o)
        5'd0, 5'd1: begin
          if (o == 5'd0) c = 0;
          u  = int'(x) + int'(y) + c;
          sv = int'($signed(x)) + int'($signed(y)) + c;
          hn = int'(x[3:0]) + int'(y[3:0]) + c;
          r = u[7:0]; we = 1;
          f[0] = u > 255; f[5] = hn > 15; f[3] = (sv > 127) || (sv < -128);
          f[1] = r == 0; f[2] = r[7];
        end
        5'd2, 5'd3, 5'd15, 5'd16, 5'd10: begin
          logic [7:0] p, q;
          p = (o == 5'd10) ? 8'h00 : x;
          q = (o == 5'd10) ? x : y;
          if (!(o == 5'd3 || o == 5'd16)) c = 0;
          u  = int'(p) - int'(q) - c;
          sv = int'($signed(p)) - int'($signed(q)) - c;
          hn = int'(p[3:0]) - int'(q[3:0]) - c;
          r = u[7:0];
          f[0] = u < 0; f[5] = hn < 0; f[3] = (sv > 127) || (sv < -128);
          f[2] = r[7];
          f[1] = (o == 5'd3 || o == 5'd16) ? (r == 0 && m_fl[1]) : (r == 0);
          if (o == 5'd15 || o == 5'd16) r = m_res; else we = 1;
        end
        5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd14: begin
          case (o)
            5'd4: r = x & y;
            5'd5, 5'd7: r = x | y;
            5'd6: r = x ^ y;
            5'd8: r = x & ~y;
            default: r = 8'h00;
          endcase
          we = 1; f[3] = 0; f[2] = r[7]; f[1] = r == 0;
        end
        5'd9: begin
          r = ~x; we = 1; f[0] = 1; f[3] = 0; f[2] = r[7]; f[1] = r == 0;
        end
        5'd11, 5'd12: begin
          r = (o == 5'd11) ? x + 8'd1 : x - 8'd1; we = 1;
          f[3] = (o == 5'd11) ? (r == 8'h80) : (r == 8'h7F);
          f[2] = r[7]; f[1] = r == 0;
        end
        5'd13: begin r = 8'hFF; we = 1; end
        default: ;
      endcase
      f[4] = f[2] ^ f[3];
    end
    m_res = r; m_fl = f;
    q_exp.push_back({r, we, f});
    q_tag.push_back(tag);
    drv = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if ({res, res_we, flags} !== 15'h0) begin
      n_fail++;
      $display("FAIL R1: got %h/%b/%b, expected 00/0/000000", res, res_we, flags);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    if ({res, res_we, flags} !== 15'h0) begin
      n_fail++;
      $display("FAIL R1: got %h/%b/%b after release, expected 00/0/000000", res, res_we, flags);
    end

    issue(1, 5'd0,  8'h0F, 8'h01, "R3");
    issue(1, 5'd0,  8'h7F, 8'h01, "R3");
    issue(1, 5'd0,  8'hFF, 8'h01, "R3");
    issue(1, 5'd1,  8'h10, 8'h20, "R3");
    issue(1, 5'd2,  8'h10, 8'h01, "R4");
    issue(1, 5'd2,  8'h00, 8'h01, "R4");
    issue(1, 5'd3,  8'h05, 8'h05, "R5");
    issue(1, 5'd2,  8'h80, 8'h01, "R4");
    issue(1, 5'd15, 8'h34, 8'h34, "R6");
    issue(1, 5'd16, 8'h12, 8'h12, "R5");
    issue(1, 5'd15, 8'h35, 8'h34, "R6");
    issue(1, 5'd16, 8'h12, 8'h12, "R5");
    issue(1, 5'd15, 8'h00, 8'h01, "R6");
    issue(1, 5'd16, 8'h01, 8'h00, "R5");
    issue(1, 5'd4,  8'hF0, 8'h3C, "R7");
    issue(1, 5'd5,  8'h80, 8'h01, "R7");
    issue(1, 5'd6,  8'hAA, 8'hAA, "R7");
    issue(1, 5'd7,  8'h10, 8'h81, "R7");
    issue(1, 5'd8,  8'hFF, 8'h0F, "R7");
    issue(1, 5'd9,  8'hFF, 8'h00, "R8");
    issue(1, 5'd10, 8'h00, 8'h00, "R9");
    issue(1, 5'd10, 8'h80, 8'h00, "R9");
    issue(1, 5'd10, 8'h01, 8'h00, "R9");
    issue(1, 5'd11, 8'h7F, 8'h00, "R10");
    issue(1, 5'd12, 8'h80, 8'h00, "R10");
    issue(1, 5'd11, 8'hFF, 8'h00, "R10");
    issue(1, 5'd13, 8'h00, 8'h00, "R11");
    issue(1, 5'd14, 8'h5A, 8'h00, "R11");
    issue(1, 5'd20, 8'h12, 8'h34, "R13");
    issue(1, 5'd31, 8'h00, 8'h00, "R13");
    issue(0, 5'd0,  8'h44, 8'h44, "R2");
    issue(0, 5'd13, 8'h44, 8'h44, "R2");

    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        issue(lf[0] | lf[1] | lf[2], 5'(lf[15:11] % 19), lf[7:0] ^ lf[15:8], lf[11:4],
              "R12");
      end
    end

    @(negedge clk);
    en = 1'b0; drv = 1'b0;
    repeat (4) @(negedge clk);
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R2: got %0d pending results, expected 0", q_exp.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule